// File: doc/BRIEF.md
# Packed-Byte SIMD Miscellaneous ALU

This block is an execution unit for a register datapath of XLEN bits (32 or 64). It treats each source operand as a vector of independent 8-bit lanes. For each lane it computes a minimum or a maximum, in signed or unsigned form. It can also clamp a lane to a range chosen by a small immediate, in signed or unsigned form. Further lane operations are a saturating absolute value and three leading-bit counts. One more operation exchanges the two bytes inside every 16-bit halfword.

The operation is computed combinationally from the operation select, rs1, rs2 and the immediate. A single register stage then captures the result and a one-cycle saturation pulse. The pulse is meant to be ORed into a sticky flag that lives elsewhere. Instruction decode, register-file access and the sticky flag itself are the surrounding pipeline's job.

Top module: `pbm_simd_misc`

## Requirements
- R1: Operation codes on `op_i` are: 0 signed min, 1 unsigned min, 2 signed max, 3 unsigned max, 4 signed clip, 5 unsigned clip, 6 saturating abs, 7 redundant-sign count, 8 leading-zero count, 9 leading-one count, 10 halfword byte swap. For codes 0 to 3, each lane of the result is the smaller or larger of the rs1 and rs2 lanes. Lanes are compared as two's-complement bytes for codes 0 and 2, and as unsigned bytes for codes 1 and 3.
- R2: Signed clip with amount n limits each rs1 lane to the range -(2^n) to 2^n-1. If the lane changes, its overflow event is raised.
- R3: Unsigned clip turns a negative rs1 lane into 0 and raises the lane's event. It limits a non-negative lane to at most 2^n-1, and raises the event if the lane changes.
- R4: The clip amount n is `imm_i[2:0]`. Bits `imm_i[4:3]` have no effect on the result or on the saturation pulse.
- R5: Saturating abs turns lane value 0x80 into 0x7F and raises the lane's event. Every other lane becomes its ordinary absolute value.
- R6: The leading-zero count is 0 when the lane's bit 7 is set, and 8 for a zero lane. The leading-one count is 0 when bit 7 is clear, and 8 for lane 0xFF. Both counts cover only the 8 bits of the lane.
- R7: The redundant-sign count is the number of consecutive bits below bit 7 that equal bit 7. Its value lies in 0 to 7.
- R8: Byte swap exchanges the low and high byte of every 16-bit halfword of rs1.
- R9: `sat_o` is the OR of all lane overflow events. It is never raised for operation codes other than 4, 5 and 6.
- R10: `result_o` and `sat_o` appear one clock after their inputs. A synchronous active-low reset clears both to zero.
- R11: Operation codes 11 to 15 produce a zero result and no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation select |
| rs1_i | input | XLEN | First source operand |
| rs2_i | input | XLEN | Second source operand (min and max only) |
| imm_i | input | 5 | Clip amount field; only the low 3 bits are used |
| result_o | output | XLEN | Registered lane-wise result |
| sat_o | output | 1 | Registered saturation pulse |

## Verification
Two things can happen in the same cycle and must not disturb each other: one lane saturates while a neighbouring lane passes through unchanged, and the OR of lane events drives the single flag. To provoke this, the bench builds operand words that cycle the corner bytes 0x00, 0x7F, 0x80 and 0xFF across lanes. It combines these words with every clip amount and with random lanes. A lane-level model predicts each byte and the single flag. A pass needs every untouched lane to match exactly, and the flag to be set exactly when at least one lane was altered.

// File: rtl/pbm_pkg.sv
// Shared definitions for the packed-byte miscellaneous ALU.
// Assumes lanes are always 8 bits wide; XLEN is set on the top module.
package pbm_pkg;
    localparam int LANE_W = 8;
    localparam int CNT_W  = $clog2(LANE_W + 1);

    typedef enum logic [3:0] {
        OP_SMIN  = 4'd0,
        OP_UMIN  = 4'd1,
        OP_SMAX  = 4'd2,
        OP_UMAX  = 4'd3,
        OP_SCLIP = 4'd4,
        OP_UCLIP = 4'd5,
        OP_SABS  = 4'd6,
        OP_CLRS  = 4'd7,
        OP_CLZ   = 4'd8,
        OP_CLO   = 4'd9,
        OP_SWAP  = 4'd10
    } pbm_op_e;
endpackage

// File: rtl/pbm_lead_count.sv
// Counts how many bits, starting at the MSB and going down, equal match_i.
// Pure combinational. The result saturates at W when every bit matches.
module pbm_lead_count #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    input  logic          match_i,
    output logic [CW-1:0] count_o
);
    // Walk the bits from the top, stopping at the first mismatch.
    always_comb begin
        logic stop;
        stop    = 1'b0;
        count_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stop && (bits_i[i] == match_i)) begin
                count_o = count_o + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pbm_lane.sv
// One 8-bit lane of the miscellaneous ALU: min/max, clip, abs, leading counts.
// Pure combinational. The swap operation and unknown codes give zero here;
// swap is assembled at word level by the top module.
module pbm_lane
    import pbm_pkg::*;
(
    input  pbm_op_e           op_i,
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  logic [2:0]        amt_i,
    output logic [LANE_W-1:0] res_o,
    output logic              ovf_o
);
    logic              s_lt, u_lt;
    logic [8:0]        pow;
    logic signed [8:0] a_ext, hi_s, lo_s;
    logic [CNT_W-1:0]  sign_cnt;

    // Comparisons and clip bounds shared by several operations.
    always_comb begin
        s_lt  = $signed(a_i) < $signed(b_i);
        u_lt  = a_i < b_i;
        pow   = 9'd1 << amt_i;
        hi_s  = $signed(pow) - 9'sd1;
        lo_s  = -$signed(pow);
        a_ext = $signed({a_i[7], a_i});
    end

    // A single run-length counter against the sign bit serves all three counts.
    pbm_lead_count #(.W(LANE_W), .CW(CNT_W)) u_cnt (
        .bits_i  (a_i),
        .match_i (a_i[7]),
        .count_o (sign_cnt)
    );

    // Select the lane result and flag the overflow event.
    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        case (op_i)
            OP_SMIN: res_o = s_lt ? a_i : b_i;
            OP_UMIN: res_o = u_lt ? a_i : b_i;
            OP_SMAX: res_o = s_lt ? b_i : a_i;
            OP_UMAX: res_o = u_lt ? b_i : a_i;
            OP_SCLIP: begin
                if (a_ext > hi_s) begin
                    res_o = hi_s[7:0];
                    ovf_o = 1'b1;
                end else if (a_ext < lo_s) begin
                    res_o = lo_s[7:0];
                    ovf_o = 1'b1;
                end else begin
                    res_o = a_i;
                end
            end
            OP_UCLIP: begin
                if (a_i[7]) begin
                    res_o = '0;
                    ovf_o = 1'b1;
                end else if (a_ext > hi_s) begin
                    res_o = hi_s[7:0];
                    ovf_o = 1'b1;
                end else begin
                    res_o = a_i;
                end
            end
            OP_SABS: begin
                if (a_i == 8'h80) begin
                    res_o = 8'h7F;
                    ovf_o = 1'b1;
                end else begin
                    res_o = a_i[7] ? (~a_i + 8'd1) : a_i;
                end
            end
            OP_CLRS: res_o = {{(LANE_W-CNT_W){1'b0}}, sign_cnt - 1'b1};
            OP_CLZ:  res_o = a_i[7] ? '0 : {{(LANE_W-CNT_W){1'b0}}, sign_cnt};
            OP_CLO:  res_o = a_i[7] ? {{(LANE_W-CNT_W){1'b0}}, sign_cnt} : '0;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/pbm_simd_misc.sv
// Top of the packed-byte miscellaneous ALU. Replicates one lane per byte,
// builds the halfword swap, and registers the result and saturation pulse.
// Assumes XLEN is a multiple of 16. The reset is synchronous and active low.
module pbm_simd_misc
    import pbm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    input  logic [4:0]      imm_i,
    output logic [XLEN-1:0] result_o,
    output logic            sat_o
);
    localparam int LANES = XLEN / LANE_W;
    localparam int HALVES = XLEN / 16;

    pbm_op_e         op_e;
    logic [XLEN-1:0] lane_res;
    logic [XLEN-1:0] swap_word;
    logic [LANES-1:0] lane_ovf;
    logic            unused_imm;

    assign op_e       = pbm_op_e'(op_i);
    assign unused_imm = ^imm_i[4:3];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pbm_lane u_lane (
            .op_i  (op_e),
            .a_i   (rs1_i[g*LANE_W +: LANE_W]),
            .b_i   (rs2_i[g*LANE_W +: LANE_W]),
            .amt_i (imm_i[2:0]),
            .res_o (lane_res[g*LANE_W +: LANE_W]),
            .ovf_o (lane_ovf[g])
        );
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_swap
        assign swap_word[h*16 +: 8]     = rs1_i[h*16 + 8 +: 8];
        assign swap_word[h*16 + 8 +: 8] = rs1_i[h*16 +: 8];
    end

    // Output register: word result and OR of the lane events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            sat_o    <= 1'b0;
        end else begin
            result_o <= (op_e == OP_SWAP) ? swap_word : lane_res;
            sat_o    <= |lane_ovf;
        end
    end
endmodule

// File: rtl/pbm_simd_misc_chk.sv
// Property checker for pbm_simd_misc, attached by bind below.
// Each property looks one cycle back, to the inputs that fed the register.
module pbm_simd_misc_chk
    import pbm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      op_i,
    input logic [XLEN-1:0] rs1_i,
    input logic [XLEN-1:0] result_o,
    input logic            sat_o
);
    localparam int LANES = XLEN / 8;

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !sat_o));

    p_no_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_i != OP_SCLIP && op_i != OP_UCLIP && op_i != OP_SABS) |=> !sat_o);

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_i > 4'd10) |=> (result_o == '0));

    p_abs_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_i == OP_SABS && rs1_i[7:0] == 8'h80) |=> (result_o[7:0] == 8'h7F && sat_o));

    p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && op_i == OP_SWAP) |=> (result_o[15:8] == $past(rs1_i[7:0]) && result_o[7:0] == $past(rs1_i[15:8])));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        p_uclip_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && op_i == OP_UCLIP && rs1_i[g*8+7]) |=> (result_o[g*8 +: 8] == 8'h00 && sat_o));

        p_clz_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && op_i == OP_CLZ && rs1_i[g*8+7]) |=> (result_o[g*8 +: 8] == 8'h00));

        p_clrs_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && op_i == OP_CLRS) |=> (result_o[g*8 +: 8] <= 8'd7));
    end
endmodule

bind pbm_simd_misc pbm_simd_misc_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .rs1_i    (rs1_i),
    .result_o (result_o),
    .sat_o    (sat_o)
);

// File: tb/test_pbm_simd_misc.sv
module test_pbm_simd_misc;
    localparam int XLEN  = 64;
    localparam int LANES = XLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      op_i = '0;
    logic [XLEN-1:0] rs1_i = '0;
    logic [XLEN-1:0] rs2_i = '0;
    logic [4:0]      imm_i = '0;
    logic [XLEN-1:0] result_o;
    logic            sat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [XLEN-1:0] res;
        logic            sat;
        string           tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    pbm_simd_misc #(.XLEN(XLEN)) i_pbm_simd_misc (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .rs1_i(rs1_i),
        .rs2_i(rs2_i), .imm_i(imm_i), .result_o(result_o), .sat_o(sat_o)
    );

    // Lane model built from the requirement text: {event, byte}.
    function automatic logic [8:0] ref_lane(input int op, input logic [7:0] a,
                                            input logic [7:0] b, input int n);
        int sa, sb2, ua, ub, r, hi, lo, k;
        bit o, run;
        sa = int'($signed(a)); sb2 = int'($signed(b));
        ua = int'(a); ub = int'(b);
        hi = (1 << n) - 1; lo = -(1 << n);
        r = 0; o = 0; k = 0; run = 1;
        case (op)
            0: r = (sa < sb2) ? sa : sb2;
            1: r = (ua < ub) ? ua : ub;
            2: r = (sa > sb2) ? sa : sb2;
            3: r = (ua > ub) ? ua : ub;
            4: begin
                if (sa > hi) begin r = hi; o = 1; end
                else if (sa < lo) begin r = lo; o = 1; end
                else r = sa;
            end
            5: begin
                if (sa < 0) begin r = 0; o = 1; end
                else if (sa > hi) begin r = hi; o = 1; end
                else r = sa;
            end
            6: begin
                if (sa == -128) begin r = 127; o = 1; end
                else r = (sa < 0) ? -sa : sa;
            end
            7: begin
                for (int i = 6; i >= 0; i--) begin
                    if (run && a[i] == a[7]) k++; else run = 0;
                end
                r = k;
            end
            8: begin
                for (int i = 7; i >= 0; i--) begin
                    if (run && !a[i]) k++; else run = 0;
                end
                r = k;
            end
            9: begin
                for (int i = 7; i >= 0; i--) begin
                    if (run && a[i]) k++; else run = 0;
                end
                r = k;
            end
            default: r = 0;
        endcase
        return {o, r[7:0]};
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0, 1, 2, 3: return "R1";
            4:          return "R2";
            5:          return "R3";
            6:          return "R5";
            7:          return "R7";
            8, 9:       return "R6";
            10:         return "R8";
            default:    return "R11";
        endcase
    endfunction

    // Driver: apply one operation and push its expected outcome.
    task automatic drive(input int op, input logic [XLEN-1:0] a,
                         input logic [XLEN-1:0] b, input logic [4:0] imm,
                         input string tag);
        exp_t e;
        logic [8:0] l;
        @(negedge clk);
        op_i = 4'(op); rs1_i = a; rs2_i = b; imm_i = imm;
        e.res = '0; e.sat = 1'b0; e.tag = tag;
        if (op == 10) begin
            for (int h = 0; h < XLEN / 16; h++) begin
                e.res[h*16 +: 8]     = a[h*16 + 8 +: 8];
                e.res[h*16 + 8 +: 8] = a[h*16 +: 8];
            end
        end else begin
            for (int g = 0; g < LANES; g++) begin
                l = ref_lane(op, a[g*8 +: 8], b[g*8 +: 8], int'(imm[2:0]));
                e.res[g*8 +: 8] = l[7:0];
                e.sat = e.sat | l[8];
            end
        end
        sb.push_back(e);
    endtask

    // Monitor: compare each registered result one cycle after its inputs.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (result_o !== e.res || sat_o !== e.sat) begin
                    fails++;
                    $display("FAIL %s (sat R9): result=%h sat=%b expected result=%h sat=%b",
                             e.tag, result_o, sat_o, e.res, e.sat);
                end
            end
        end
    end

    function automatic logic [XLEN-1:0] rnd();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [XLEN-1:0] corner_mix(input int rot);
        logic [7:0] cs [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        logic [XLEN-1:0] w;
        w = '0;
        for (int g = 0; g < LANES; g++) w[g*8 +: 8] = cs[(g + rot) % 4];
        return w;
    endfunction

    task automatic check_zero(input string what);
        checks++;
        if (result_o !== '0 || sat_o !== 1'b0) begin
            fails++;
            $display("FAIL R10 %s: result=%h sat=%b expected result=0 sat=0",
                     what, result_o, sat_o);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] cs [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        repeat (3) @(posedge clk);
        #1;
        check_zero("reset state");
        @(negedge clk);
        rst_n = 1'b1;

        for (int op = 0; op <= 10; op++) begin
            for (int n = 0; n < 8; n++) begin
                for (int c = 0; c < 4; c++) begin
                    drive(op, {LANES{cs[c]}}, rnd(), 5'(n), op_tag(op));
                    drive(op, corner_mix(c), corner_mix(c + 1), 5'(n), op_tag(op));
                end
                drive(op, rnd(), rnd(), 5'(n), op_tag(op));
            end
            for (int i = 0; i < 40; i++) drive(op, rnd(), rnd(), 5'($urandom % 8), op_tag(op));
        end

        // R4: upper immediate bits must not change the clip outcome.
        for (int n = 0; n < 8; n++) begin
            drive(4, corner_mix(n), rnd(), {2'b11, 3'(n)}, "R4");
            drive(5, corner_mix(n), rnd(), {2'b10, 3'(n)}, "R4");
            drive(5, rnd(), rnd(), {2'b01, 3'(n)}, "R4");
        end

        // R11: reserved operation codes.
        for (int op = 11; op < 16; op++) begin
            drive(op, rnd(), rnd(), 5'h1F, "R11");
            drive(op, {LANES{8'h80}}, rnd(), 5'h00, "R11");
        end

        // R9: one saturating lane among pass-through lanes.
        drive(6, 64'h0102_0304_0580_0607, '0, 5'd0, "R9");
        drive(4, 64'h0000_0000_0000_0040, '0, 5'd5, "R9");

        repeat (3) @(posedge clk);
        #1;

        // R10: mid-run reset clears a saturating result.
        @(negedge clk);
        op_i = 4'd6; rs1_i = {LANES{8'h80}}; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_zero("mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (result_o !== {LANES{8'h7F}} || sat_o !== 1'b1) begin
            fails++;
            $display("FAIL R10 after reset: result=%h sat=%b expected result=%h sat=1",
                     result_o, sat_o, {LANES{8'h7F}});
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule